// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside the write engine of a sector-programmed non-volatile memory. It watches the stream of byte loads that the bus interface has already latched, each one an address/data pair qualified by a one-cycle strobe. It recognises multi-step unlock sequences in that stream. Every sequence starts with the same two-byte prefix. From these sequences it keeps four persistent flags: software write protection, product-identification read mode, and a programming lockout for each of the two boot blocks.

For every load the block reports one cycle later whether the load is ordinary sector data and whether that data may actually change the array. A protected but unauthorised load still counts as data, so the write engine starts its timer and writes nothing. While identification mode is on, a combinational read override returns the maker and device codes and the lockout status of each boot block. The lockout flags also block chip erase.

Top module: `unlock_decoder`

## Requirements
- R1: After reset, protectOn, idModeOn, lockLow, lockHigh, eraseBlock and outValid are all 0.
- R2: The prefix (AAh to address 5555h, then 55h to 2AAAh) followed by A0h to 5555h sets protectOn. It also authorises the data loads that follow: they report outPermit=1 until a cycleEnd pulse.
- R3: While protectOn=1 and no authorisation is pending, a data load reports outIsData=1 and outPermit=0.
- R4: Prefix, 80h to 5555h, prefix, 20h to 5555h clears protectOn. All six loads are commands.
- R5: Prefix plus 90h to 5555h sets idModeOn and prefix plus F0h to 5555h clears it. In that mode, read address 0 gives idHit=1 with idData=1Fh, and read address 1 gives A4h.
- R6: Prefix, 80h, prefix, 40h, then 00h to address 00000h sets lockLow. The same six steps followed by FFh to 7FFFFh set lockHigh. No sequence clears a lockout flag, and eraseBlock is 1 while either flag is set.
- R7: In identification mode, read address 00002h reports the lower block and 7FFF2h reports the upper block. The value is FEh when the block is writable and FFh when it is locked.
- R8: A data load whose address bits 18..14 are all 0 (lower block) or all 1 (upper block) reports outPermit=0 while that block is locked, whatever the protection state. A load outside both blocks is unaffected.
- R9: A load that breaks a partial sequence returns the decoder to idle. If it is not itself AAh to 5555h, it is reported as data (outIsData=1). Loads the decoder consumes as command steps report outIsData=0.
- R10: Command steps compare only address bits 14..0, so higher address bits do not matter. The final lockout step compares the full 19-bit address.
- R11: Each load strobe produces exactly one outValid pulse in the following cycle, carrying outIsData and outPermit for that load.
- R12: idHit is 0 and idData is 00h when identification mode is off or the read address is not one of 0, 1, 2 or 7FFF2h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | One latched byte load this cycle |
| loadAddr | input | 19 | Address of the load |
| loadData | input | 8 | Data of the load |
| cycleEnd | input | 1 | Write engine finished a program cycle; ends authorisation |
| readAddr | input | 19 | Address of the current read |
| outValid | output | 1 | Verdict for the previous cycle's load |
| outIsData | output | 1 | That load is sector data (starts the program timer) |
| outPermit | output | 1 | That load may change the array |
| protectOn | output | 1 | Software write protection active |
| idModeOn | output | 1 | Identification read mode active |
| lockLow | output | 1 | Lower boot block locked |
| lockHigh | output | 1 | Upper boot block locked |
| eraseBlock | output | 1 | Chip erase inhibited |
| idHit | output | 1 | Read data is overridden |
| idData | output | 8 | Override read data |

## Verification
Most faults in the sequence state show up on the verdict of the very next load. A decoder stuck partway through a sequence marks an ordinary byte as a command (outIsData=0) or passes a command byte through as data, one cycle after that load. A wrong flag shows up directly on protectOn, idModeOn or the lock outputs in the cycle after the last step of a sequence. It is also visible on outPermit for the next data load and in idData as soon as readAddr selects a status location.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int CMD_W = 15;
  localparam logic [CMD_W-1:0] KEY_MAIN = 15'h5555;
  localparam logic [CMD_W-1:0] KEY_ALT  = 15'h2AAA;
  localparam logic [7:0] BYTE_FIRST  = 8'hAA;
  localparam logic [7:0] BYTE_SECOND = 8'h55;
  localparam logic [7:0] OP_PROTECT  = 8'hA0;
  localparam logic [7:0] OP_EXTEND   = 8'h80;
  localparam logic [7:0] OP_UNPROT   = 8'h20;
  localparam logic [7:0] OP_LOCKARM  = 8'h40;
  localparam logic [7:0] OP_IDENTER  = 8'h90;
  localparam logic [7:0] OP_IDEXIT   = 8'hF0;
  localparam logic [7:0] LOCK_LO_KEY = 8'h00;
  localparam logic [7:0] LOCK_HI_KEY = 8'hFF;
  localparam logic [7:0] MAKER_CODE  = 8'h1F;
  localparam logic [7:0] DEVICE_CODE = 8'hA4;
  localparam logic [7:0] BLOCK_OPEN  = 8'hFE;
  localparam logic [7:0] BLOCK_SHUT  = 8'hFF;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_PRE1, SEQ_PRE2, SEQ_EXT, SEQ_EXT1, SEQ_EXT2, SEQ_LOCK
  } seq_t;

  typedef struct packed {
    logic setProt;
    logic clrProt;
    logic setAuth;
    logic setId;
    logic clrId;
    logic setLockLo;
    logic setLockHi;
    logic passData;
  } strobe_t;
endpackage

// File: rtl/unlock_ctrl.sv
module unlock_ctrl
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  output strobe_t           strobes
);
  seq_t state, nextSt;
  logic atMain, atAlt, isFirst, isSecond, broken;
  logic [CMD_W-1:0] cmdAddr;

  assign cmdAddr  = loadAddr[CMD_W-1:0];
  assign atMain   = (cmdAddr == KEY_MAIN);
  assign atAlt    = (cmdAddr == KEY_ALT);
  assign isFirst  = atMain && (loadData == BYTE_FIRST);
  assign isSecond = atAlt && (loadData == BYTE_SECOND);

  always_comb begin
    strobes = '0;
    nextSt  = state;
    broken  = 1'b0;
    if (loadValid) begin
      nextSt = SEQ_IDLE;
      case (state)
        SEQ_IDLE: broken = 1'b1;
        SEQ_PRE1: if (isSecond) nextSt = SEQ_PRE2; else broken = 1'b1;
        SEQ_PRE2: begin
          if (!atMain) broken = 1'b1;
          else begin
            case (loadData)
              OP_PROTECT: begin
                strobes.setProt = 1'b1;
                strobes.setAuth = 1'b1;
              end
              OP_IDENTER: strobes.setId = 1'b1;
              OP_IDEXIT:  strobes.clrId = 1'b1;
              OP_EXTEND:  nextSt = SEQ_EXT;
              default:    broken = 1'b1;
            endcase
          end
        end
        SEQ_EXT:  if (isFirst) nextSt = SEQ_EXT1; else broken = 1'b1;
        SEQ_EXT1: if (isSecond) nextSt = SEQ_EXT2; else broken = 1'b1;
        SEQ_EXT2: begin
          if (atMain && loadData == OP_UNPROT) strobes.clrProt = 1'b1;
          else if (atMain && loadData == OP_LOCKARM) nextSt = SEQ_LOCK;
          else broken = 1'b1;
        end
        SEQ_LOCK: begin
          if (loadAddr == '0 && loadData == LOCK_LO_KEY) strobes.setLockLo = 1'b1;
          else if (loadAddr == '1 && loadData == LOCK_HI_KEY) strobes.setLockHi = 1'b1;
          else broken = 1'b1;
        end
        default: broken = 1'b1;
      endcase
      // A non-matching byte is re-examined as if the decoder were idle
      if (broken) begin
        if (isFirst) nextSt = SEQ_PRE1;
        else strobes.passData = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else state <= nextSt;
  end
endmodule

// File: rtl/unlock_datapath.sv
module unlock_datapath
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BOOT_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              cycleEnd,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] readAddr,
  output logic              outValid,
  output logic              outIsData,
  output logic              outPermit,
  output logic              protectOn,
  output logic              idModeOn,
  output logic              lockLow,
  output logic              lockHigh,
  output logic              idHit,
  output logic [7:0]        idData
);
  localparam int TAG_W = ADDR_W - BOOT_W;
  localparam logic [ADDR_W-1:0] LO_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] HI_STAT = {{(ADDR_W-4){1'b1}}, 4'h2};

  logic authOn, inLow, inHigh, blocked, permitNow;

  assign inLow     = (loadAddr[ADDR_W-1:BOOT_W] == {TAG_W{1'b0}});
  assign inHigh    = (loadAddr[ADDR_W-1:BOOT_W] == {TAG_W{1'b1}});
  assign blocked   = (lockLow && inLow) || (lockHigh && inHigh);
  assign permitNow = strobes.passData && !blocked && (!protectOn || authOn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protectOn <= 1'b0;
      authOn    <= 1'b0;
      idModeOn  <= 1'b0;
      lockLow   <= 1'b0;
      lockHigh  <= 1'b0;
      outValid  <= 1'b0;
      outIsData <= 1'b0;
      outPermit <= 1'b0;
    end else begin
      if (strobes.setProt) protectOn <= 1'b1;
      else if (strobes.clrProt) protectOn <= 1'b0;
      if (strobes.setAuth) authOn <= 1'b1;
      else if (cycleEnd) authOn <= 1'b0;
      if (strobes.setId) idModeOn <= 1'b1;
      else if (strobes.clrId) idModeOn <= 1'b0;
      if (strobes.setLockLo) lockLow <= 1'b1;
      if (strobes.setLockHi) lockHigh <= 1'b1;
      outValid  <= loadValid;
      outIsData <= strobes.passData;
      outPermit <= permitNow;
    end
  end

  always_comb begin
    idHit  = 1'b0;
    idData = 8'h00;
    if (idModeOn) begin
      idHit = 1'b1;
      if (readAddr == '0) idData = MAKER_CODE;
      else if (readAddr == ADDR_W'(1)) idData = DEVICE_CODE;
      else if (readAddr == LO_STAT) idData = lockLow ? BLOCK_SHUT : BLOCK_OPEN;
      else if (readAddr == HI_STAT) idData = lockHigh ? BLOCK_SHUT : BLOCK_OPEN;
      else idHit = 1'b0;
    end
  end
endmodule

// File: rtl/unlock_decoder.sv
module unlock_decoder
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BOOT_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  input  logic              cycleEnd,
  input  logic [ADDR_W-1:0] readAddr,
  output logic              outValid,
  output logic              outIsData,
  output logic              outPermit,
  output logic              protectOn,
  output logic              idModeOn,
  output logic              lockLow,
  output logic              lockHigh,
  output logic              eraseBlock,
  output logic              idHit,
  output logic [7:0]        idData
);
  strobe_t strobes;

  unlock_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadValid(loadValid),
    .loadAddr(loadAddr), .loadData(loadData), .strobes(strobes)
  );

  unlock_datapath #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_dp (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadAddr(loadAddr),
    .cycleEnd(cycleEnd), .strobes(strobes), .readAddr(readAddr),
    .outValid(outValid), .outIsData(outIsData), .outPermit(outPermit),
    .protectOn(protectOn), .idModeOn(idModeOn), .lockLow(lockLow),
    .lockHigh(lockHigh), .idHit(idHit), .idData(idData)
  );

  assign eraseBlock = lockLow | lockHigh;
endmodule

// File: rtl/unlock_decoder_chk.sv
module unlock_decoder_chk #(
  parameter int ADDR_W = 19,
  parameter int BOOT_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadValid,
  input logic [ADDR_W-1:0] loadAddr,
  input logic [7:0]        loadData,
  input logic              outValid,
  input logic              outIsData,
  input logic              outPermit,
  input logic              protectOn,
  input logic              idModeOn,
  input logic              lockLow,
  input logic              lockHigh,
  input logic              eraseBlock,
  input logic              idHit
);
  p_verdict_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> outValid);
  p_no_stray_verdict_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(loadValid));
  p_permit_is_data_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outPermit) |-> outIsData);
  p_low_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    lockLow |=> lockLow);
  p_high_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    lockHigh |=> lockHigh);
  p_erase_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lockLow || lockHigh) |-> eraseBlock);
  p_locked_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outPermit) |->
      !($past(lockLow) && $past(loadAddr[ADDR_W-1:BOOT_W]) == '0));
  p_prot_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protectOn) |-> ($past(loadValid) && $past(loadData) == 8'hA0));
  p_id_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    idHit |-> idModeOn);
endmodule

bind unlock_decoder unlock_decoder_chk #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_chk (
  .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadAddr(loadAddr),
  .loadData(loadData), .outValid(outValid), .outIsData(outIsData),
  .outPermit(outPermit), .protectOn(protectOn), .idModeOn(idModeOn),
  .lockLow(lockLow), .lockHigh(lockHigh), .eraseBlock(eraseBlock), .idHit(idHit)
);

// File: tb/unlock_decoder_test.sv
module unlock_decoder_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadValid = 1'b0;
  logic [18:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic cycleEnd = 1'b0;
  logic [18:0] readAddr = '0;
  logic outValid, outIsData, outPermit, protectOn, idModeOn;
  logic lockLow, lockHigh, eraseBlock, idHit;
  logic [7:0] idData;

  int total = 0;
  int fails = 0;
  logic [1:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  unlock_decoder uut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadAddr(loadAddr),
    .loadData(loadData), .cycleEnd(cycleEnd), .readAddr(readAddr),
    .outValid(outValid), .outIsData(outIsData), .outPermit(outPermit),
    .protectOn(protectOn), .idModeOn(idModeOn), .lockLow(lockLow),
    .lockHigh(lockHigh), .eraseBlock(eraseBlock), .idHit(idHit), .idData(idData)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic doLoad(input logic [18:0] a, input logic [7:0] d,
                        input logic expData, input logic expPerm, input string tag);
    expQ.push_back({expData, expPerm});
    tagQ.push_back(tag);
    @(negedge clk);
    loadValid = 1'b1; loadAddr = a; loadData = d;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic cmd(input logic [18:0] a, input logic [7:0] d, input string tag);
    doLoad(a, d, 1'b0, 1'b0, tag);
  endtask

  task automatic prefix(input string tag);
    cmd(19'h05555, 8'hAA, tag);
    cmd(19'h02AAA, 8'h55, tag);
  endtask

  task automatic pulseEnd();
    @(negedge clk); cycleEnd = 1'b1;
    @(negedge clk); cycleEnd = 1'b0;
  endtask

  task automatic readChk(input logic [18:0] a, input logic expHit,
                         input logic [7:0] expData, input string tag);
    readAddr = a;
    #1;
    check(idHit, expHit, tag, "idHit");
    check(idData, expData, tag, "idData");
  endtask

  // Scoreboard monitor for per-load verdicts (R11)
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && outValid) begin
        if (expQ.size() == 0) begin
          total++; fails++;
          $display("FAIL R11 unexpected verdict: actual 1 expected 0");
        end else begin
          logic [1:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(outIsData, e[1], t, "outIsData");
          check(outPermit, e[0], t, "outPermit");
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(protectOn, 0, "R1", "protectOn");
    check(idModeOn, 0, "R1", "idModeOn");
    check({lockLow, lockHigh, eraseBlock}, 0, "R1", "locks");
    check(outValid, 0, "R1", "outValid");
    rstN = 1'b1;
    @(negedge clk);

    // R11 / R8: plain load outside boot blocks
    doLoad(19'h10000, 8'h12, 1, 1, "R11");

    // R2 enable protection and authorised load
    prefix("R2");
    cmd(19'h05555, 8'hA0, "R2");
    check(protectOn, 1, "R2", "protectOn");
    doLoad(19'h20100, 8'h34, 1, 1, "R2");
    pulseEnd();
    // R3 unauthorised load while protected
    doLoad(19'h20100, 8'h35, 1, 0, "R3");

    // R9 break byte becomes data; decoder back to idle
    cmd(19'h05555, 8'hAA, "R9");
    doLoad(19'h03000, 8'h33, 1, 0, "R9");
    doLoad(19'h02AAA, 8'h55, 1, 0, "R9");

    // R10 upper address bits ignored in command steps
    cmd(19'h7D555, 8'hAA, "R10");
    cmd(19'h12AAA, 8'h55, "R10");
    cmd(19'h45555, 8'hA0, "R10");
    doLoad(19'h20200, 8'h77, 1, 1, "R10");
    pulseEnd();

    // R4 disable protection
    prefix("R4");
    cmd(19'h05555, 8'h80, "R4");
    prefix("R4");
    cmd(19'h05555, 8'h20, "R4");
    check(protectOn, 0, "R4", "protectOn");
    doLoad(19'h20300, 8'h11, 1, 1, "R4");

    // R5 identification mode
    readChk(19'h00000, 0, 8'h00, "R12");
    prefix("R5");
    cmd(19'h05555, 8'h90, "R5");
    check(idModeOn, 1, "R5", "idModeOn");
    readChk(19'h00000, 1, 8'h1F, "R5");
    readChk(19'h00001, 1, 8'hA4, "R5");
    readChk(19'h00002, 1, 8'hFE, "R7");
    readChk(19'h7FFF2, 1, 8'hFE, "R7");
    readChk(19'h00005, 0, 8'h00, "R12");

    // R6 lock lower block
    prefix("R6");
    cmd(19'h05555, 8'h80, "R6");
    prefix("R6");
    cmd(19'h05555, 8'h40, "R6");
    cmd(19'h00000, 8'h00, "R6");
    check(lockLow, 1, "R6", "lockLow");
    check(lockHigh, 0, "R6", "lockHigh");
    check(eraseBlock, 1, "R6", "eraseBlock");
    readChk(19'h00002, 1, 8'hFF, "R7");
    readChk(19'h7FFF2, 1, 8'hFE, "R7");

    // R5 exit identification mode
    prefix("R5");
    cmd(19'h05555, 8'hF0, "R5");
    check(idModeOn, 0, "R5", "idModeOn");
    readChk(19'h00000, 0, 8'h00, "R12");

    // R8 locked block refuses data, other block accepts
    doLoad(19'h01000, 8'h44, 1, 0, "R8");
    doLoad(19'h7C000, 8'h45, 1, 1, "R8");

    // R6 lock upper block with full-address compare
    prefix("R6");
    cmd(19'h05555, 8'h80, "R6");
    prefix("R6");
    cmd(19'h05555, 8'h40, "R6");
    cmd(19'h7FFFF, 8'hFF, "R6");
    check(lockHigh, 1, "R6", "lockHigh");
    doLoad(19'h7C010, 8'h46, 1, 0, "R8");

    // R9 break at final lockout step goes through as data
    prefix("R9");
    cmd(19'h05555, 8'h80, "R9");
    prefix("R9");
    cmd(19'h05555, 8'h40, "R9");
    doLoad(19'h00001, 8'h00, 1, 0, "R9");
    doLoad(19'h30000, 8'h00, 1, 1, "R9");

    // R6 lockouts survive protect enable/disable
    prefix("R6");
    cmd(19'h05555, 8'hA0, "R6");
    prefix("R6");
    cmd(19'h05555, 8'h80, "R6");
    prefix("R6");
    cmd(19'h05555, 8'h20, "R6");
    check({lockLow, lockHigh}, 2'b11, "R6", "locks sticky");

    repeat (3) @(negedge clk);
    check(expQ.size(), 0, "R11", "pending verdicts");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule